// File: doc/BRIEF.md
# Relative Branch Condition Unit

This block resolves the short-displacement jump group of a small processor. Each cycle it takes an opcode, an 8-bit displacement, the address of the instruction that follows the jump (the pointer has already moved past the 2-byte jump), and the Zero and Carry flags. It decides whether the opcode is a relative jump and whether that jump is taken. It then produces the branch target and the address to fetch next.

The comparison forms use the subtract-with-carry convention. In that convention, Carry set means "no borrow". So "less than" is taken when Carry is clear, and "greater or equal" is taken when Carry is set. All outputs are registered, so a result appears one clock after its inputs are presented. Flag generation, fetch, and the absolute and subroutine jumps are handled elsewhere.

Top module: `rel_branch_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, all outputs become zero on that edge, regardless of the other inputs.
- R2: Opcode 0x31 is an unconditional jump: `br_valid` and `br_taken` are 1 for every flag combination.
- R3: Opcode 0x30 is taken when Zero is 0, and opcode 0x32 is taken when Zero is 1. Carry has no effect on either.
- R4: Opcode 0x33 (less than) is taken when Carry is 0, and opcode 0x34 (greater or equal) is taken when Carry is 1. Zero has no effect on either.
- R5: Opcode 0x35 (greater than) is taken only when Zero is 0 and Carry is 1.
- R6: Opcode 0x36 (less or equal) is taken when Zero is 1 or Carry is 0.
- R7: `br_target` equals `ip_next` plus the two's-complement sign extension of `offset`, modulo 2^16, for every opcode.
- R8: When `br_taken` is 1, `next_ip` equals `br_target`. Otherwise `next_ip` equals the `ip_next` that was presented.
- R9: An opcode below 0x30 or above 0x36 gives `br_valid` = 0 and `br_taken` = 0, whatever the flags are.
- R10: Each output reflects the inputs sampled at the previous rising edge, a latency of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 8 | Opcode of the current instruction |
| offset | input | 8 | Signed displacement byte |
| ip_next | input | 16 | Address of the instruction after the jump |
| flag_zero | input | 1 | Zero flag |
| flag_carry | input | 1 | Carry flag (1 = no borrow) |
| br_valid | output | 1 | Opcode belongs to the relative jump group |
| br_taken | output | 1 | The jump is taken |
| br_target | output | 16 | ip_next plus the sign-extended displacement |
| next_ip | output | 16 | Address to fetch next |

## Verification
Two things are resolved in the same cycle: the condition decision and the 16-bit target sum that wraps around. The decision selects whether the wrapped sum or the fall-through address reaches `next_ip`. The bench sweeps every opcode against all four flag combinations, using pointer and displacement pairs that overflow past 0xFFFF and underflow below 0x0000. It then sweeps all 256 displacements at addresses next to both wrap points. Each result is compared with values computed arithmetically from the requirements: the taken decision, the wrapped target, and the choice of next address.

// File: rtl/rbu_pkg.sv
// Shared types for the relative branch unit.
// Assumes the jump group occupies seven consecutive opcodes.
package rbu_pkg;

    // Branch condition selected by the decoder.
    typedef enum logic [2:0] {
        COND_NONE   = 3'd0,
        COND_ALWAYS = 3'd1,
        COND_ZCLR   = 3'd2,
        COND_ZSET   = 3'd3,
        COND_CCLR   = 3'd4,
        COND_CSET   = 3'd5,
        COND_ABOVE  = 3'd6,
        COND_NABOVE = 3'd7
    } cond_e;

    localparam int GROUP_SIZE = 7;

endpackage

// File: rtl/rbu_decode.sv
// Maps an opcode to a branch condition.
// Assumes the group starts at OPC_BASE; the order of the seven
// conditions within the group is fixed by the instruction encoding.
module rbu_decode #(
    parameter int                 OPC_W    = 8,
    parameter logic [OPC_W-1:0]   OPC_BASE = 8'h30
) (
    input  logic [OPC_W-1:0] opcode,
    output rbu_pkg::cond_e   cond,
    output logic             in_group
);
    import rbu_pkg::*;

    localparam logic [OPC_W-1:0] OPC_LAST = OPC_BASE + OPC_W'(GROUP_SIZE - 1);

    logic [OPC_W-1:0] idx;

    // Range test and index within the group.
    always_comb begin
        in_group = (opcode >= OPC_BASE) && (opcode <= OPC_LAST);
        idx      = opcode - OPC_BASE;
    end

    // Index to condition, following the group encoding order.
    always_comb begin
        cond = COND_NONE;
        if (in_group) begin
            case (idx[2:0])
                3'd0:    cond = COND_ZCLR;
                3'd1:    cond = COND_ALWAYS;
                3'd2:    cond = COND_ZSET;
                3'd3:    cond = COND_CCLR;
                3'd4:    cond = COND_CSET;
                3'd5:    cond = COND_ABOVE;
                3'd6:    cond = COND_NABOVE;
                default: cond = COND_NONE;
            endcase
        end
    end

endmodule

// File: rtl/rbu_cond_eval.sv
// Evaluates a branch condition against the Zero and Carry flags.
// Assumes Carry set means "no borrow" after a compare.
module rbu_cond_eval (
    input  rbu_pkg::cond_e cond,
    input  logic           zf,
    input  logic           cf,
    output logic           take
);
    import rbu_pkg::*;

    // Flag test for each condition.
    always_comb begin
        case (cond)
            COND_ALWAYS: take = 1'b1;
            COND_ZCLR:   take = ~zf;
            COND_ZSET:   take = zf;
            COND_CCLR:   take = ~cf;
            COND_CSET:   take = cf;
            COND_ABOVE:  take = ~zf & cf;
            COND_NABOVE: take = zf | ~cf;
            default:     take = 1'b0;
        endcase
    end

endmodule

// File: rtl/rbu_target_add.sv
// Adds an extended displacement to an address, wrapping at 2^ADDR_W.
// SIGNED_OFS selects sign extension (1) or zero extension (0).
// Assumes ADDR_W > OFS_W.
module rbu_target_add #(
    parameter int ADDR_W     = 16,
    parameter int OFS_W      = 8,
    parameter bit SIGNED_OFS = 1'b1
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFS_W-1:0]  ofs,
    output logic [ADDR_W-1:0] sum
);
    localparam int EXT_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] ofs_ext;

    generate
        if (SIGNED_OFS) begin : g_sext
            // Replicate the sign bit of the displacement.
            always_comb ofs_ext = {{EXT_W{ofs[OFS_W-1]}}, ofs};
        end else begin : g_zext
            // Pad the displacement with zeros.
            always_comb ofs_ext = {{EXT_W{1'b0}}, ofs};
        end
    endgenerate

    // Modular sum; the carry out is dropped.
    always_comb sum = base + ofs_ext;

endmodule

// File: rtl/rel_branch_unit.sv
// Relative branch condition unit: decodes the relative jump group,
// evaluates its condition, and registers the taken flag, the target
// and the next fetch address. One cycle of latency.
// Assumes ip_next already points past the 2-byte jump.
module rel_branch_unit #(
    parameter int               ADDR_W   = 16,
    parameter int               OFS_W    = 8,
    parameter int               OPC_W    = 8,
    parameter logic [OPC_W-1:0] OPC_BASE = 8'h30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [OFS_W-1:0]  offset,
    input  logic [ADDR_W-1:0] ip_next,
    input  logic              flag_zero,
    input  logic              flag_carry,
    output logic              br_valid,
    output logic              br_taken,
    output logic [ADDR_W-1:0] br_target,
    output logic [ADDR_W-1:0] next_ip
);
    import rbu_pkg::*;

    cond_e             cond;
    logic              in_group;
    logic              take;
    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] sel_ip;

    rbu_decode #(.OPC_W(OPC_W), .OPC_BASE(OPC_BASE)) i_decode (
        .opcode   (opcode),
        .cond     (cond),
        .in_group (in_group)
    );

    rbu_cond_eval i_eval (
        .cond (cond),
        .zf   (flag_zero),
        .cf   (flag_carry),
        .take (take)
    );

    rbu_target_add #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .SIGNED_OFS(1'b1)) i_add (
        .base (ip_next),
        .ofs  (offset),
        .sum  (sum)
    );

    // Choose the fetch address: target on a taken jump, fall-through otherwise.
    always_comb sel_ip = take ? sum : ip_next;

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            br_valid  <= 1'b0;
            br_taken  <= 1'b0;
            br_target <= '0;
            next_ip   <= '0;
        end else begin
            br_valid  <= in_group;
            br_taken  <= take;
            br_target <= sum;
            next_ip   <= sel_ip;
        end
    end

endmodule

// File: rtl/rel_branch_unit_chk.sv
// Checker for rel_branch_unit; relates registered outputs to the
// inputs of the previous cycle. Attached by the bind at the bottom.
module rel_branch_unit_chk #(
    parameter int               ADDR_W   = 16,
    parameter int               OFS_W    = 8,
    parameter int               OPC_W    = 8,
    parameter logic [OPC_W-1:0] OPC_BASE = 8'h30
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OPC_W-1:0]  opcode,
    input logic [OFS_W-1:0]  offset,
    input logic [ADDR_W-1:0] ip_next,
    input logic              flag_zero,
    input logic              flag_carry,
    input logic              br_valid,
    input logic              br_taken,
    input logic [ADDR_W-1:0] br_target,
    input logic [ADDR_W-1:0] next_ip
);
    localparam int EXT_W = ADDR_W - OFS_W;

    logic past_ok = 1'b0;
    logic rst_seen = 1'b0;

    // past_ok: the previous edge captured inputs rather than reset.
    always_ff @(posedge clk) begin
        past_ok  <= rst_n;
        rst_seen <= ~rst_n;
    end

    // R1: an edge with reset low leaves zero outputs.
    always_ff @(posedge clk) begin
        if (rst_seen) begin
            a_r1_reset_zero: assert (!br_valid && !br_taken && br_target == '0 && next_ip == '0);
        end
    end

    a_r2_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(opcode) == OPC_BASE + OPC_W'(1) |-> br_valid && br_taken);

    a_r3_zero_clear: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(opcode) == OPC_BASE |-> br_taken == !$past(flag_zero));

    a_r3_zero_set: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(opcode) == OPC_BASE + OPC_W'(2) |-> br_taken == $past(flag_zero));

    a_r4_less: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(opcode) == OPC_BASE + OPC_W'(3) |-> br_taken == !$past(flag_carry));

    a_r4_geq: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(opcode) == OPC_BASE + OPC_W'(4) |-> br_taken == $past(flag_carry));

    a_r5_greater: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(opcode) == OPC_BASE + OPC_W'(5)
        |-> br_taken == (!$past(flag_zero) && $past(flag_carry)));

    a_r6_leq: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(opcode) == OPC_BASE + OPC_W'(6)
        |-> br_taken == ($past(flag_zero) || !$past(flag_carry)));

    a_r7_target_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> br_target == ADDR_W'($past(ip_next)
                    + {{EXT_W{$past(offset[OFS_W-1])}}, $past(offset)}));

    a_r8_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !br_taken |-> next_ip == $past(ip_next));

    a_r8_taken_target: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> next_ip == br_target);

    a_r9_outside_group: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && ($past(opcode) < OPC_BASE || $past(opcode) > OPC_BASE + OPC_W'(6))
        |-> !br_valid && !br_taken);

endmodule

bind rel_branch_unit rel_branch_unit_chk #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .OPC_W(OPC_W), .OPC_BASE(OPC_BASE)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .opcode     (opcode),
    .offset     (offset),
    .ip_next    (ip_next),
    .flag_zero  (flag_zero),
    .flag_carry (flag_carry),
    .br_valid   (br_valid),
    .br_taken   (br_taken),
    .br_target  (br_target),
    .next_ip    (next_ip)
);

// File: tb/test_rel_branch_unit.sv
`timescale 1ns/1ps
// Sweep bench for rel_branch_unit: all opcodes x all flags x wrap pairs,
// then all displacements at both wrap points.
module test_rel_branch_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  opcode = '0;
    logic [7:0]  offset = '0;
    logic [15:0] ip_next = '0;
    logic        flag_zero = 1'b0;
    logic        flag_carry = 1'b0;
    logic        br_valid;
    logic        br_taken;
    logic [15:0] br_target;
    logic [15:0] next_ip;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rel_branch_unit i_rel_branch_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .opcode     (opcode),
        .offset     (offset),
        .ip_next    (ip_next),
        .flag_zero  (flag_zero),
        .flag_carry (flag_carry),
        .br_valid   (br_valid),
        .br_taken   (br_taken),
        .br_target  (br_target),
        .next_ip    (next_ip)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s op=%h ofs=%h ip=%h z=%b c=%b actual=%h expected=%h",
                     req, opcode, offset, ip_next, flag_zero, flag_carry, act, exp);
        end
    endtask

    // Expected taken decision per requirement (R2..R6, R9).
    function automatic bit exp_take(input logic [7:0] op, input bit z, input bit c);
        case (op)
            8'h31:   return 1'b1;          // R2
            8'h30:   return !z;            // R3
            8'h32:   return z;             // R3
            8'h33:   return !c;            // R4
            8'h34:   return c;             // R4
            8'h35:   return !z && c;       // R5
            8'h36:   return z || !c;       // R6
            default: return 1'b0;          // R9
        endcase
    endfunction

    // Present one vector at a falling edge, check at the next falling edge (R10).
    task automatic run_vec(input logic [7:0] op, input logic [7:0] ofs,
                           input logic [15:0] ip, input bit z, input bit c);
        logic [15:0] tgt;
        bit tk;
        @(negedge clk);
        opcode = op; offset = ofs; ip_next = ip; flag_zero = z; flag_carry = c;
        tgt = 16'((32'(ip) + 32'($signed(ofs)) + 32'h10000) & 32'hFFFF);  // R7
        tk  = exp_take(op, z, c);
        @(negedge clk);
        check((op >= 8'h30 && op <= 8'h36) ? "R2-group valid" : "R9 valid",
              16'(br_valid), 16'(op >= 8'h30 && op <= 8'h36));
        check("R3/R4/R5/R6 taken", 16'(br_taken), 16'(tk));
        check("R7 target", br_target, tgt);
        check("R8 next_ip", next_ip, tk ? tgt : ip);
    endtask

    initial begin
        // R1: reset with busy inputs.
        opcode = 8'h31; offset = 8'h7F; ip_next = 16'h1234; flag_zero = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 valid", 16'(br_valid), 16'h0);
        check("R1 taken", 16'(br_taken), 16'h0);
        check("R1 target", br_target, 16'h0);
        check("R1 next_ip", next_ip, 16'h0);
        rst_n = 1'b1;

        // All opcodes x flags x pointer/displacement pairs, incl. wrap cases.
        for (int p = 0; p < 4; p++) begin
            logic [15:0] ip;
            logic [7:0]  ofs;
            case (p)
                0: begin ip = 16'h1000; ofs = 8'h10; end
                1: begin ip = 16'hFFF8; ofs = 8'h20; end  // overflow past 0xFFFF
                2: begin ip = 16'h0004; ofs = 8'hF0; end  // underflow below 0
                default: begin ip = 16'h8000; ofs = 8'h80; end
            endcase
            for (int op = 0; op < 256; op++) begin
                for (int f = 0; f < 4; f++) begin
                    run_vec(8'(op), ofs, ip, f[1], f[0]);
                end
            end
        end

        // R7: every displacement at both wrap points, taken and not taken.
        for (int o = 0; o < 256; o++) begin
            run_vec(8'h31, 8'(o), 16'hFFF0, 1'b0, 1'b0);
            run_vec(8'h32, 8'(o), 16'h0005, 1'b0, 1'b1);
        end

        // R1: reset in mid-run clears held state.
        run_vec(8'h31, 8'h05, 16'hABCD, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run valid", 16'(br_valid), 16'h0);
        check("R1 mid-run next_ip", next_ip, 16'h0);
        rst_n = 1'b1;
        run_vec(8'h35, 8'hFE, 16'h0001, 1'b0, 1'b1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run is reported as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule